// File: doc/BRIEF.md
# FSK Caller-ID Serializer

This block turns caller-ID bytes written by a host into a binary FSK tone. A host writes each byte into a holding register. When the serializer finishes its current character, or is idle, it moves the held byte into its own shift register. At that moment it raises an interrupt, so the host can write the next byte while the current one is still being sent. A bit timer counts pulses of an external sample tick, about 24 kHz, to set the bit period. For example, 20 ticks gives roughly 1200 baud. A mode bit chooses between framed characters with start and stop bits and raw 8-bit characters.

The line bit drives a phase accumulator that advances once per tick. The step size comes from the space or mark frequency register, and the phase is never reset, so the tone stays continuous when the bit changes. A quarter-wave sine table, scaled by the space or mark amplitude register, gives a signed sample. Only bits [15:3] of the frequency and amplitude registers are significant.

Top module: `cid_fsk_tx`

## Requirements
- R1: A write to address 0 stores bits [7:0] of the data bus in a holding register. A byte written while a character is being shifted is sent directly after that character, with no idle bit between them.
- R2: The interrupt output rises on the clock edge at which a held byte enters the shift register, which is the same edge at which the first bit of that byte appears on the line. It stays high until the host writes address 7 with bit 0 set.
- R3: With mode bit 0 of address 1 clear (the reset value), each character is 10 bits: a start bit of 0, then the eight data bits least-significant first, then a stop bit of 1.
- R4: With mode bit 0 of address 1 set, each character is the eight data bits least-significant first, with no start or stop bit.
- R5: Each bit lasts exactly N tick pulses, where N is the value at address 2. A new character starts only on a tick, and each character raises the interrupt exactly once.
- R6: While address 2 holds 0, no character starts, the line stays at 1, and a byte already held is kept. It is sent once a non-zero period is written.
- R7: If a character ends while the holding register is empty, the line returns to 1 and the underrun output goes high. Writing address 7 with bit 1 set clears the underrun output.
- R8: After reset the interrupt and underrun outputs are 0, the line bit is 1, and the phase and sample outputs are 0.
- R9: On every tick the phase output advances by the space frequency (address 3) when the line bit is 0, or by the mark frequency (address 4) when it is 1, modulo 2^16, with bits [2:0] of each frequency ignored. Without a tick the phase holds, and it is never reset when the bit changes.
- R10: The magnitude of the sample never exceeds half of the selected amplitude: address 5 for a space bit, address 6 for a mark bit, with bits [2:0] ignored. When the selected amplitude is 0, the sample is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle sample tick (about 24 kHz) |
| wr_en_i | input | 1 | Host register write strobe |
| wr_addr_i | input | 3 | Host register address |
| wr_data_i | input | 16 | Host write data |
| line_bit_o | output | 1 | Current line bit (1 = mark) |
| irq_o | output | 1 | Next byte may be written |
| underrun_o | output | 1 | A character ended with no byte held |
| phase_o | output | 16 | Phase accumulator |
| sample_o | output | 16 | Signed tone sample |

## Verification
The framed bytes A5, 3C and 00 are sent back to back. Alternating bits check LSB-first order and the framing bits, while the all-zero byte separates a real stop bit from the idle level and exposes any gap between buffered characters. In raw mode, bytes FF and 81 show that no start or stop bit is added. A tick on every other clock with a period of 3 separates counting ticks from counting clocks. A zero period checks that a held byte waits, and a zero space amplitude, written with only ignored low bits set, checks both amplitude selection and the masking. Across all of these, a running model of the phase checks that each step matches the current bit and that no reset occurs at mark/space changes.

// File: rtl/cid_fsk_pkg.sv
// Shared definitions for the FSK caller-ID serializer.
// Assumes a host bus with an eight-entry register space.
package cid_fsk_pkg;

    localparam int ADDR_W = 3;

    // Host register addresses; the bench and the host depend on these values.
    typedef enum logic [ADDR_W-1:0] {
        REG_DATA    = 3'd0,
        REG_MODE    = 3'd1,
        REG_BITTIME = 3'd2,
        REG_FSPACE  = 3'd3,
        REG_FMARK   = 3'd4,
        REG_ASPACE  = 3'd5,
        REG_AMARK   = 3'd6,
        REG_STATUS  = 3'd7
    } reg_addr_e;

    // Bit positions in the status clear word.
    localparam int CLR_IRQ_BIT = 0;
    localparam int CLR_UDR_BIT = 1;

endpackage

// File: rtl/cid_fsk_regs.sv
// Host register file: holding byte, mode, bit period, tone settings and
// the sticky interrupt and underrun flags.
// Assumes one write per cycle. A data write in the same cycle as a load keeps
// the holding register full with the new byte.
module cid_fsk_regs
    import cid_fsk_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int REG_W   = 16,
    parameter int TIMER_W = 16,
    parameter int IGN_LSB = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [REG_W-1:0]   wr_data_i,
    input  logic               load_i,
    input  logic               underrun_set_i,
    output logic               hold_full_o,
    output logic [DATA_W-1:0]  hold_byte_o,
    output logic               raw8_o,
    output logic [TIMER_W-1:0] bit_time_o,
    output logic [REG_W-1:0]   f_space_o,
    output logic [REG_W-1:0]   f_mark_o,
    output logic [REG_W-1:0]   a_space_o,
    output logic [REG_W-1:0]   a_mark_o,
    output logic               irq_o,
    output logic               underrun_o
);

    localparam logic [REG_W-1:0] SIG_MASK = {{(REG_W-IGN_LSB){1'b1}}, {IGN_LSB{1'b0}}};

    logic wr_data_sel;
    logic wr_status_sel;

    // Decode the two writes that interact with the serializer.
    always_comb begin
        wr_data_sel   = wr_en_i && (wr_addr_i == REG_DATA);
        wr_status_sel = wr_en_i && (wr_addr_i == REG_STATUS);
    end

    // Holding register: filled by a host write, emptied by the serializer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full_o <= 1'b0;
            hold_byte_o <= '0;
        end else if (wr_data_sel) begin
            hold_full_o <= 1'b1;
            hold_byte_o <= wr_data_i[DATA_W-1:0];
        end else if (load_i) begin
            hold_full_o <= 1'b0;
        end
    end

    // Configuration registers; insignificant low bits are stored as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw8_o     <= 1'b0;
            bit_time_o <= '0;
            f_space_o  <= '0;
            f_mark_o   <= '0;
            a_space_o  <= '0;
            a_mark_o   <= '0;
        end else if (wr_en_i) begin
            case (wr_addr_i)
                REG_MODE:    raw8_o     <= wr_data_i[0];
                REG_BITTIME: bit_time_o <= TIMER_W'(wr_data_i);
                REG_FSPACE:  f_space_o  <= wr_data_i & SIG_MASK;
                REG_FMARK:   f_mark_o   <= wr_data_i & SIG_MASK;
                REG_ASPACE:  a_space_o  <= wr_data_i & SIG_MASK;
                REG_AMARK:   a_mark_o   <= wr_data_i & SIG_MASK;
                default:     ;
            endcase
        end
    end

    // Interrupt flag: set on each load, cleared by write-one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else if (load_i) begin
            irq_o <= 1'b1;
        end else if (wr_status_sel && wr_data_i[CLR_IRQ_BIT]) begin
            irq_o <= 1'b0;
        end
    end

    // Underrun flag: set when a character ends unfed, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underrun_o <= 1'b0;
        end else if (underrun_set_i) begin
            underrun_o <= 1'b1;
        end else if (wr_status_sel && wr_data_i[CLR_UDR_BIT]) begin
            underrun_o <= 1'b0;
        end
    end

endmodule

// File: rtl/cid_fsk_serializer.sv
// Character serializer with a tick-driven bit timer.
// Framed mode sends 0, data LSB first, then 1; raw mode sends the data only.
// Assumes the holding register clears itself on load_o. The mode is latched
// per character, and a zero bit period stops transmission at once.
module cid_fsk_serializer #(
    parameter int DATA_W  = 8,
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [TIMER_W-1:0] bit_time_i,
    input  logic               raw8_i,
    input  logic               hold_full_i,
    input  logic [DATA_W-1:0]  hold_byte_i,
    output logic               load_o,
    output logic               underrun_o,
    output logic               line_bit_o
);

    localparam int FRAME_LEN = DATA_W + 2;
    localparam int RAW_LEN   = DATA_W;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] FRAME_LAST = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] RAW_LAST   = IDX_W'(RAW_LEN - 1);
    localparam logic [TIMER_W-1:0] TIMER_ONE = TIMER_W'(1);

    logic               running_q;
    logic               raw_q;
    logic [IDX_W-1:0]   bidx_q;
    logic [TIMER_W-1:0] tcnt_q;
    logic [DATA_W-1:0]  shreg_q;

    logic             enabled;
    logic             bit_end;
    logic             char_end;
    logic             shift_now;
    logic [IDX_W-1:0] last_idx;

    // Timing decisions for the current cycle.
    always_comb begin
        enabled   = (bit_time_i != '0);
        last_idx  = raw_q ? RAW_LAST : FRAME_LAST;
        bit_end   = enabled && (tcnt_q >= (bit_time_i - TIMER_ONE));
        char_end  = running_q && tick_i && bit_end && (bidx_q == last_idx);
        shift_now = raw_q || ((bidx_q != '0) && (bidx_q != FRAME_LAST));
        load_o    = hold_full_i && enabled && tick_i && (!running_q || char_end);
        underrun_o = char_end && !hold_full_i;
    end

    // Line level: mark when idle, otherwise the framing or data bit.
    always_comb begin
        if (!running_q) begin
            line_bit_o = 1'b1;
        end else if (raw_q) begin
            line_bit_o = shreg_q[0];
        end else if (bidx_q == '0) begin
            line_bit_o = 1'b0;
        end else if (bidx_q == FRAME_LAST) begin
            line_bit_o = 1'b1;
        end else begin
            line_bit_o = shreg_q[0];
        end
    end

    // Character state: stop, load, advance the bit timer and the index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            raw_q     <= 1'b0;
            bidx_q    <= '0;
            tcnt_q    <= '0;
            shreg_q   <= '0;
        end else if (running_q && !enabled) begin
            running_q <= 1'b0;
            bidx_q    <= '0;
            tcnt_q    <= '0;
        end else if (load_o) begin
            running_q <= 1'b1;
            raw_q     <= raw8_i;
            bidx_q    <= '0;
            tcnt_q    <= '0;
            shreg_q   <= hold_byte_i;
        end else if (running_q && tick_i) begin
            if (bit_end) begin
                tcnt_q <= '0;
                if (shift_now) begin
                    shreg_q <= shreg_q >> 1;
                end
                if (char_end) begin
                    running_q <= 1'b0;
                    bidx_q    <= '0;
                end else begin
                    bidx_q <= bidx_q + 1'b1;
                end
            end else begin
                tcnt_q <= tcnt_q + TIMER_ONE;
            end
        end
    end

endmodule

// File: rtl/cid_fsk_nco.sv
// Continuous-phase tone source: a phase accumulator stepped once per tick by
// the frequency that the line bit selects, and a quarter-wave sine table
// scaled by the selected amplitude.
// Assumes a 16-entry quarter table and SAMPLE_W of 16. The phase is never
// cleared except by reset.
module cid_fsk_nco #(
    parameter int PHASE_W  = 16,
    parameter int AMP_W    = 16,
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic                       line_bit_i,
    input  logic [PHASE_W-1:0]         f_space_i,
    input  logic [PHASE_W-1:0]         f_mark_i,
    input  logic [AMP_W-1:0]           a_space_i,
    input  logic [AMP_W-1:0]           a_mark_i,
    output logic [PHASE_W-1:0]         phase_o,
    output logic signed [SAMPLE_W-1:0] sample_o
);

    localparam int LUT_BITS = 4;
    localparam int MAG_W    = SAMPLE_W - 1;
    localparam int PROD_W   = MAG_W + AMP_W;

    logic [LUT_BITS-1:0]        lut_idx;
    logic [MAG_W-1:0]           sine_mag;
    logic [AMP_W-1:0]           amp_sel;
    logic [PROD_W-1:0]          prod;
    logic [MAG_W-1:0]           mag;
    logic signed [SAMPLE_W-1:0] mag_s;

    // Quarter-wave sine at cell centres, full scale 32767.
    function automatic logic [MAG_W-1:0] quarter_sine(input logic [LUT_BITS-1:0] i);
        case (i)
            4'd0:  quarter_sine = MAG_W'(1608);
            4'd1:  quarter_sine = MAG_W'(4808);
            4'd2:  quarter_sine = MAG_W'(7962);
            4'd3:  quarter_sine = MAG_W'(11039);
            4'd4:  quarter_sine = MAG_W'(14010);
            4'd5:  quarter_sine = MAG_W'(16846);
            4'd6:  quarter_sine = MAG_W'(19519);
            4'd7:  quarter_sine = MAG_W'(22005);
            4'd8:  quarter_sine = MAG_W'(24279);
            4'd9:  quarter_sine = MAG_W'(26319);
            4'd10: quarter_sine = MAG_W'(28106);
            4'd11: quarter_sine = MAG_W'(29621);
            4'd12: quarter_sine = MAG_W'(30852);
            4'd13: quarter_sine = MAG_W'(31785);
            4'd14: quarter_sine = MAG_W'(32412);
            default: quarter_sine = MAG_W'(32728);
        endcase
    endfunction

    // Phase accumulator: one step per tick, no reset on a bit change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o <= '0;
        end else if (tick_i) begin
            phase_o <= phase_o + (line_bit_i ? f_mark_i : f_space_i);
        end
    end

    // Sample: fold the phase into the quarter table, scale it, apply the sign.
    always_comb begin
        lut_idx  = phase_o[PHASE_W-3 -: LUT_BITS];
        if (phase_o[PHASE_W-2]) begin
            lut_idx = ~lut_idx;
        end
        sine_mag = quarter_sine(lut_idx);
        amp_sel  = line_bit_i ? a_mark_i : a_space_i;
        prod     = PROD_W'(sine_mag) * PROD_W'(amp_sel);
        mag      = MAG_W'(prod >> AMP_W);
        mag_s    = {1'b0, mag};
        sample_o = phase_o[PHASE_W-1] ? -mag_s : mag_s;
    end

endmodule

// File: rtl/cid_fsk_tx.sv
// Top level of the FSK caller-ID serializer: the register file feeds the
// serializer, whose line bit steers the continuous-phase tone source.
// Assumes tick_i is a one-cycle pulse at the sample rate.
module cid_fsk_tx
    import cid_fsk_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int REG_W    = 16,
    parameter int TIMER_W  = 16,
    parameter int IGN_LSB  = 3,
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [REG_W-1:0]           wr_data_i,
    output logic                       line_bit_o,
    output logic                       irq_o,
    output logic                       underrun_o,
    output logic [REG_W-1:0]           phase_o,
    output logic signed [SAMPLE_W-1:0] sample_o
);

    logic               load;
    logic               underrun_set;
    logic               hold_full;
    logic [DATA_W-1:0]  hold_byte;
    logic               raw8;
    logic [TIMER_W-1:0] bit_time;
    logic [REG_W-1:0]   f_space;
    logic [REG_W-1:0]   f_mark;
    logic [REG_W-1:0]   a_space;
    logic [REG_W-1:0]   a_mark;

    cid_fsk_regs #(
        .DATA_W (DATA_W),
        .REG_W  (REG_W),
        .TIMER_W(TIMER_W),
        .IGN_LSB(IGN_LSB)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en_i),
        .wr_addr_i     (wr_addr_i),
        .wr_data_i     (wr_data_i),
        .load_i        (load),
        .underrun_set_i(underrun_set),
        .hold_full_o   (hold_full),
        .hold_byte_o   (hold_byte),
        .raw8_o        (raw8),
        .bit_time_o    (bit_time),
        .f_space_o     (f_space),
        .f_mark_o      (f_mark),
        .a_space_o     (a_space),
        .a_mark_o      (a_mark),
        .irq_o         (irq_o),
        .underrun_o    (underrun_o)
    );

    cid_fsk_serializer #(
        .DATA_W (DATA_W),
        .TIMER_W(TIMER_W)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .bit_time_i (bit_time),
        .raw8_i     (raw8),
        .hold_full_i(hold_full),
        .hold_byte_i(hold_byte),
        .load_o     (load),
        .underrun_o (underrun_set),
        .line_bit_o (line_bit_o)
    );

    cid_fsk_nco #(
        .PHASE_W (REG_W),
        .AMP_W   (REG_W),
        .SAMPLE_W(SAMPLE_W)
    ) u_nco (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .line_bit_i(line_bit_o),
        .f_space_i (f_space),
        .f_mark_i  (f_mark),
        .a_space_i (a_space),
        .a_mark_i  (a_mark),
        .phase_o   (phase_o),
        .sample_o  (sample_o)
    );

endmodule

// File: rtl/cid_fsk_tx_checks.sv
// Property checker for cid_fsk_tx, attached to every instance by bind.
// Relates ports and the signals passed between the submodules.
module cid_fsk_tx_checks
    import cid_fsk_pkg::*;
#(
    parameter int REG_W    = 16,
    parameter int TIMER_W  = 16,
    parameter int SAMPLE_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tick_i,
    input logic                       wr_en_i,
    input logic [ADDR_W-1:0]          wr_addr_i,
    input logic                       line_bit_o,
    input logic                       irq_o,
    input logic                       underrun_o,
    input logic [REG_W-1:0]           phase_o,
    input logic signed [SAMPLE_W-1:0] sample_o,
    input logic                       load,
    input logic                       hold_full,
    input logic [TIMER_W-1:0]         bit_time,
    input logic [REG_W-1:0]           f_space,
    input logic [REG_W-1:0]           f_mark,
    input logic [REG_W-1:0]           a_space,
    input logic [REG_W-1:0]           a_mark
);

    // R1: a load empties the holding stage unless a new byte arrives with it.
    assert_hold_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !(wr_en_i && wr_addr_i == REG_DATA)) |=> !hold_full);

    // R2: every load raises the interrupt.
    assert_irq_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> irq_o);

    // R5: the line bit changes only on a tick while the period is non-zero.
    assert_bit_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick_i) && $past(bit_time) != '0) |-> $stable(line_bit_o));

    // R6: a zero period never starts a character.
    assert_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_time == '0) |-> !load);

    // R7: an underrun leaves the line at mark.
    assert_underrun_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun_o) |-> line_bit_o);

    // R9: each tick steps the phase by the frequency of the bit then on the line.
    assert_phase_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick_i)) |->
        phase_o == $past(phase_o) + ($past(line_bit_o) ? $past(f_mark) : $past(f_space)));

    // R9: the phase holds between ticks.
    assert_phase_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick_i)) |-> $stable(phase_o));

    // R10: a zero selected amplitude yields a silent sample.
    assert_amp_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_bit_o ? a_mark : a_space) == '0) |-> (sample_o == '0));

endmodule

bind cid_fsk_tx cid_fsk_tx_checks #(
    .REG_W   (REG_W),
    .TIMER_W (TIMER_W),
    .SAMPLE_W(SAMPLE_W)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .line_bit_o(line_bit_o),
    .irq_o     (irq_o),
    .underrun_o(underrun_o),
    .phase_o   (phase_o),
    .sample_o  (sample_o),
    .load      (load),
    .hold_full (hold_full),
    .bit_time  (bit_time),
    .f_space   (f_space),
    .f_mark    (f_mark),
    .a_space   (a_space),
    .a_mark    (a_mark)
);

// File: tb/cid_fsk_tx_test.sv
// Scoreboard bench: the driver queues each expected character as it writes it,
// and the monitor pops and compares the bits as they leave the line.
module cid_fsk_tx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        line_bit;
    logic        irq;
    logic        underrun;
    logic [15:0] phase;
    logic signed [15:0] sample;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    bit tick_en = 1'b0;
    int tcount = 0;
    int per = 4;
    int sent = 0;
    int seen = 0;
    bit cfg_busy = 1'b1;
    string cur_tag = "R3";
    logic [19:0] expq[$];
    logic [15:0] fsp = '0, fmk = '0, asp = '0, amk = '0;

    cid_fsk_tx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .line_bit_o(line_bit),
        .irq_o     (irq),
        .underrun_o(underrun),
        .phase_o   (phase),
        .sample_o  (sample)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Tick source, updated with non-blocking writes at the clock edge.
    initial forever begin
        @(posedge clk);
        tick <= tick_en && (tcount % tick_div == 0);
        tcount++;
    end

    task automatic wreg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push_char(input logic [7:0] b, input bit raw);
        if (raw) expq.push_back({4'd8, 2'b00, 6'd0, b});
        else     expq.push_back({4'd10, 6'd0, 1'b1, b, 1'b0});
        sent++;
    endtask

    task automatic await_load();
        while (!irq) @(negedge clk);
        wreg(3'd7, 16'h0001);
        chk(irq == 1'b0, "R2", "irq after clear", irq, 0);
    endtask

    task automatic await_end();
        while (!underrun) @(negedge clk);
        chk(line_bit == 1'b1, "R7", "line after underrun", line_bit, 1);
        wreg(3'd7, 16'h0002);
        chk(underrun == 1'b0, "R7", "underrun after clear", underrun, 0);
    endtask

    task automatic set_tone(input logic [15:0] fs, input logic [15:0] fm,
                            input logic [15:0] as, input logic [15:0] am);
        cfg_busy = 1'b1; tick_en = 1'b0;
        repeat (3) @(negedge clk);
        wreg(3'd3, fs); wreg(3'd4, fm); wreg(3'd5, as); wreg(3'd6, am);
        fsp = fs & 16'hFFF8; fmk = fm & 16'hFFF8; asp = as & 16'hFFF8; amk = am & 16'hFFF8;
        repeat (2) @(negedge clk);
        cfg_busy = 1'b0; tick_en = 1'b1;
    endtask

    // Monitor: each interrupt rise starts a character; sample every bit mid-period.
    initial begin
        logic prev;
        logic [19:0] e;
        int len;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && irq && !prev) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R2", "unexpected interrupt", 1, 0);
                end else begin
                    e = expq.pop_front();
                    len = int'(e[19:16]);
                    seen++;
                    for (int j = 0; j < len; j++) begin
                        repeat ((j == 0) ? per / 2 : per) @(negedge clk);
                        chk(line_bit == e[j], cur_tag, $sformatf("line bit %0d", j), line_bit, e[j]);
                    end
                end
            end
            prev = irq;
        end
    end

    // Phase and amplitude model (R9, R10), evaluated every cycle.
    initial begin
        logic [15:0] pphase, expect_ph, a;
        logic pline, ptick, pvalid;
        int mag;
        pvalid = 1'b0; pphase = '0; pline = 1'b1; ptick = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && pvalid && !cfg_busy) begin
                expect_ph = pphase + (ptick ? (pline ? fmk : fsp) : 16'h0000);
                chk(phase == expect_ph, "R9", "phase", phase, expect_ph);
                a = line_bit ? amk : asp;
                mag = (sample < 0) ? -int'(sample) : int'(sample);
                chk(mag <= int'(a) / 2 && (a != 0 || sample == 0), "R10", "sample magnitude", mag, int'(a) / 2);
            end
            pphase = phase; pline = line_bit; ptick = tick; pvalid = rst_n;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", "run did not finish", 0, 1);
        finish_sim();
    end

    // Driver.
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq == 1'b0, "R8", "irq at reset", irq, 0);
        chk(underrun == 1'b0, "R8", "underrun at reset", underrun, 0);
        chk(line_bit == 1'b1, "R8", "line at reset", line_bit, 1);
        chk(phase == 16'h0000, "R8", "phase at reset", phase, 0);
        chk(sample == 16'sd0, "R8", "sample at reset", sample, 0);

        set_tone(16'h1A2F, 16'h2E5D, 16'h8005, 16'hFFFF);
        wreg(3'd2, 16'd4);
        per = 4;

        // R1 R3: three framed bytes back to back.
        cur_tag = "R3";
        push_char(8'hA5, 1'b0); wreg(3'd0, 16'h00A5); await_load();
        push_char(8'h3C, 1'b0); wreg(3'd0, 16'h003C); await_load();
        chk(underrun == 1'b0, "R1", "no gap while fed", underrun, 0);
        push_char(8'h00, 1'b0); wreg(3'd0, 16'h0000); await_load();
        chk(underrun == 1'b0, "R1", "no gap while fed", underrun, 0);
        await_end();

        // R4: raw characters.
        wreg(3'd1, 16'h0001);
        cur_tag = "R4";
        push_char(8'hFF, 1'b1); wreg(3'd0, 16'h00FF); await_load();
        push_char(8'h81, 1'b1); wreg(3'd0, 16'h0081); await_load();
        await_end();
        wreg(3'd1, 16'h0000);

        // R5: ticks on every other clock, period 3 ticks.
        tick_div = 2; per = 6;
        wreg(3'd2, 16'd3);
        cur_tag = "R5";
        push_char(8'h5A, 1'b0); wreg(3'd0, 16'h005A); await_load();
        await_end();
        tick_div = 1;

        // R6: a zero period holds the byte until a period is set.
        wreg(3'd2, 16'd0);
        cur_tag = "R6";
        push_char(8'h96, 1'b0); wreg(3'd0, 16'h0096);
        repeat (60) @(negedge clk);
        chk(irq == 1'b0, "R6", "irq with zero period", irq, 0);
        chk(line_bit == 1'b1, "R6", "line with zero period", line_bit, 1);
        per = 5;
        wreg(3'd2, 16'd5);
        await_load();
        await_end();

        // R10: a space amplitude with only ignored bits set is silent.
        set_tone(16'h1A2F, 16'h2E5D, 16'h0007, 16'h4000);
        per = 4;
        wreg(3'd2, 16'd4);
        cur_tag = "R10";
        push_char(8'h0F, 1'b0); wreg(3'd0, 16'h000F); await_load();
        await_end();

        repeat (10) @(negedge clk);
        chk(expq.size() == 0, "R5", "characters left unsent", expq.size(), 0);
        chk(seen == sent, "R5", "one interrupt per character", seen, sent);
        finish_sim();
    end

endmodule